// File: doc/BRIEF.md
# Interrupt Redirection and Routing Unit

This block takes a set of external interrupt request lines and hands each request to one of several processor cores. A per-line redirection table says which 8-bit vector to present, the interrupt's own priority, which cores may take it, whether the line is masked, and how the target is chosen. In static selection every core in the destination set is interrupted together. In dynamic selection the single core in the set whose task priority is lowest receives it, and cores that tie take turns.

Software programs the table and the per-core task priority values through one write port. A rising edge on an unmasked request line latches a pending bit. The unit serves pending lines one at a time, lowest index first. It raises a request strobe for each target core, holds the vector and priority steady, and retires the pending bit once every targeted core has acknowledged. An entry whose vector lies below 0x20 is dropped and sets a sticky error flag.

Top module: `irq_router`

## Requirements
- R1: After reset no core request is raised, the vector and priority outputs read 0, the error flag is clear, every table entry is masked and every task priority is 0.
- R2: A write to address i (0..7) loads entry i from the write data: bits [7:0] vector, [11:8] priority, [15:12] destination set (bit c is core c), bit 16 selection mode (1 = dynamic), bit 17 mask (1 = masked). A write to address 8+c loads the task priority of core c from bits [3:0]. While a core request is raised, the vector and priority outputs carry the served entry's fields.
- R3: In dynamic mode exactly one request bit is raised, for the core of the destination set whose task priority is lowest.
- R4: Among dynamic candidates that tie on lowest task priority, the first one found scanning upward from a rotation pointer is chosen. The pointer moves to one past the chosen core only when a dynamic delivery is fully acknowledged. Static deliveries leave it unchanged.
- R5: In static mode the request bits equal the destination set (one core, several, or all). Each bit drops when its core acknowledges. The line stays pending until the last targeted core has acknowledged. Acknowledges from untargeted cores are ignored.
- R6: A rising edge on an unmasked line latches it pending. Pending lines are served one at a time, the lowest index first.
- R7: Rising edges on a masked line are ignored, so the line is never delivered, even after it is later unmasked.
- R8: A served entry whose vector is below 0x20 is discarded without any request and sets the error flag. The flag stays set until a write to address 12. A vector of exactly 0x20 is delivered normally.
- R9: A pending line whose destination set is empty is held pending, not delivered. It is delivered once a non-empty set is written.
- R10: While requests are outstanding, the raised request bits, vector and priority do not change except for bits dropped by acknowledges. The target is fixed at dispatch, so later task-priority writes do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | External request lines, rising-edge sensitive |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Write address: entries 0..7, task priorities 8..11, error clear 12 |
| cfgWdata | input | 18 | Write data |
| intAck | input | 4 | Per-core acknowledge |
| intReq | output | 4 | Per-core interrupt request |
| intVec | output | 8 | Vector of the delivery in progress |
| intPrio | output | 4 | Priority of the delivery in progress |
| errFlag | output | 1 | Sticky invalid-vector flag |

## Verification
The assertions assume that a core acknowledges only while its own request bit is high, and that the error-clear write never coincides with a drop. They also assume that the request lines are clean synchronous levels, so that one rising edge means one request. The stimulus drives every input on the falling clock edge and pulses a line for exactly one cycle. It acknowledges only cores that it has seen requested, apart from one deliberate stray acknowledge to an untargeted core. It clears the error flag only while no line is pending.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] MIN_VEC = 8'h20;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrPend;  // retire pending bit at clrIdx
    logic setErr;   // invalid vector dropped
    logic rotAdv;   // load rotation pointer with rotNew
  } ctrl_strb_t;
endpackage

// File: rtl/irq_router_lpsel.sv
module irq_router_lpsel #(
  parameter int N_CORE = 4,
  parameter int TPR_W  = 4,
  parameter int ROT_W  = 2
) (
  input  logic [N_CORE-1:0]       destSet,
  input  logic [N_CORE*TPR_W-1:0] tprFlat,
  input  logic [ROT_W-1:0]        rotPtr,
  output logic [N_CORE-1:0]       pick,
  output logic [ROT_W-1:0]        pickIdx
);
  logic [TPR_W-1:0]  minVal;
  logic [N_CORE-1:0] tieSet;

  // lowest task priority among the destination cores
  always_comb begin
    minVal = '1;
    for (int c = 0; c < N_CORE; c++) begin
      if (destSet[c] && (tprFlat[c*TPR_W +: TPR_W] <= minVal)) begin
        minVal = tprFlat[c*TPR_W +: TPR_W];
      end
    end
    for (int c = 0; c < N_CORE; c++) begin
      tieSet[c] = destSet[c] && (tprFlat[c*TPR_W +: TPR_W] == minVal);
    end
  end

  // first tied core at or after the rotation pointer
  always_comb begin
    int  cIdx;
    logic found;
    pick    = '0;
    pickIdx = '0;
    found   = 1'b0;
    for (int k = 0; k < N_CORE; k++) begin
      cIdx = int'(rotPtr) + k;
      if (cIdx >= N_CORE) cIdx = cIdx - N_CORE;
      if (!found && tieSet[cIdx]) begin
        found         = 1'b1;
        pick[cIdx]    = 1'b1;
        pickIdx       = ROT_W'(cIdx);
      end
    end
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int N_CORE = 4,
  parameter int TPR_W  = 4,
  parameter int PRIO_W = 4,
  parameter int CFG_W  = 18,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 3,
  parameter int ROT_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N_IRQ-1:0]    irqIn,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [CFG_W-1:0]    cfgWdata,
  input  ctrl_strb_t          strb,
  input  logic [IDX_W-1:0]    clrIdx,
  input  logic [ROT_W-1:0]    rotNew,
  output logic                anyElig,
  output logic [IDX_W-1:0]    selIdx,
  output logic [VEC_W-1:0]    selVec,
  output logic [PRIO_W-1:0]   selPrio,
  output logic [N_CORE-1:0]   selDest,
  output logic                selDyn,
  output logic [N_CORE-1:0]   dynPick,
  output logic [ROT_W-1:0]    dynIdx,
  output logic                errFlag
);
  localparam int DEST_LSB = VEC_W + PRIO_W;
  localparam int MODE_BIT = DEST_LSB + N_CORE;
  localparam int MASK_BIT = MODE_BIT + 1;
  localparam int CLR_ADDR = N_IRQ + N_CORE;

  logic [VEC_W-1:0]  vecArr  [N_IRQ];
  logic [PRIO_W-1:0] prioArr [N_IRQ];
  logic [N_CORE-1:0] destArr [N_IRQ];
  logic [N_IRQ-1:0]  dynVec, maskVec;
  logic [N_CORE*TPR_W-1:0] tprFlat;

  logic [N_IRQ-1:0] pend, irqPrev, pendSet, pendClr, elig;
  logic [ROT_W-1:0] rotPtr;

  // redirection table, one register set per line
  for (genvar g = 0; g < N_IRQ; g++) begin : g_ent
    logic [VEC_W-1:0]  vecR;
    logic [PRIO_W-1:0] prioR;
    logic [N_CORE-1:0] destR;
    logic              dynR, maskR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vecR  <= '0;
        prioR <= '0;
        destR <= '0;
        dynR  <= 1'b0;
        maskR <= 1'b1;
      end else if (cfgWe && cfgAddr == ADDR_W'(g)) begin
        vecR  <= cfgWdata[VEC_W-1:0];
        prioR <= cfgWdata[VEC_W +: PRIO_W];
        destR <= cfgWdata[DEST_LSB +: N_CORE];
        dynR  <= cfgWdata[MODE_BIT];
        maskR <= cfgWdata[MASK_BIT];
      end
    end
    assign vecArr[g]  = vecR;
    assign prioArr[g] = prioR;
    assign destArr[g] = destR;
    assign dynVec[g]  = dynR;
    assign maskVec[g] = maskR;
    assign elig[g]    = pend[g] && !maskR && (|destR);
  end

  // per-core task priority registers
  for (genvar c = 0; c < N_CORE; c++) begin : g_tpr
    logic [TPR_W-1:0] tprR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tprR <= '0;
      else if (cfgWe && cfgAddr == ADDR_W'(N_IRQ + c)) tprR <= cfgWdata[TPR_W-1:0];
    end
    assign tprFlat[c*TPR_W +: TPR_W] = tprR;
  end

  // pending latch: new edge wins over a retire in the same cycle
  assign pendSet = irqIn & ~irqPrev & ~maskVec;
  assign pendClr = strb.clrPend ? (N_IRQ'(1) << clrIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= '0;
      irqPrev <= '0;
      errFlag <= 1'b0;
      rotPtr  <= '0;
    end else begin
      irqPrev <= irqIn;
      pend    <= (pend & ~pendClr) | pendSet;
      if (strb.setErr) errFlag <= 1'b1;
      else if (cfgWe && cfgAddr == ADDR_W'(CLR_ADDR)) errFlag <= 1'b0;
      if (strb.rotAdv) rotPtr <= rotNew;
    end
  end

  // fixed-order scan, lowest index wins
  always_comb begin
    anyElig = 1'b0;
    selIdx  = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (elig[i]) begin
        anyElig = 1'b1;
        selIdx  = IDX_W'(i);
      end
    end
  end

  assign selVec  = vecArr[selIdx];
  assign selPrio = prioArr[selIdx];
  assign selDest = destArr[selIdx];
  assign selDyn  = dynVec[selIdx];

  irq_router_lpsel #(.N_CORE(N_CORE), .TPR_W(TPR_W), .ROT_W(ROT_W)) u_lpsel (
    .destSet (selDest),
    .tprFlat (tprFlat),
    .rotPtr  (rotPtr),
    .pick    (dynPick),
    .pickIdx (dynIdx)
  );

  // R8: flag persists until an explicit clear write
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(cfgWe && cfgAddr == ADDR_W'(CLR_ADDR))) |=> errFlag);

  // R3: dynamic pick is a single core inside the destination set
  a_r3_pick_in_dest: assert property (@(posedge clk) disable iff (!rstN)
    (anyElig && selDyn) |-> ($onehot(dynPick) && ((dynPick & ~selDest) == '0)));

  // R7: a masked idle line never becomes pending
  for (genvar g = 0; g < N_IRQ; g++) begin : g_mchk
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
      (!pend[g] && maskVec[g]) |=> !pend[g]);
  end
endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int N_CORE = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3,
  parameter int ROT_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                anyElig,
  input  logic [IDX_W-1:0]    selIdx,
  input  logic [VEC_W-1:0]    selVec,
  input  logic [PRIO_W-1:0]   selPrio,
  input  logic [N_CORE-1:0]   selDest,
  input  logic                selDyn,
  input  logic [N_CORE-1:0]   dynPick,
  input  logic [ROT_W-1:0]    dynIdx,
  input  logic [N_CORE-1:0]   intAck,
  output ctrl_strb_t          strb,
  output logic [IDX_W-1:0]    clrIdx,
  output logic [ROT_W-1:0]    rotNew,
  output logic [N_CORE-1:0]   intReq,
  output logic [VEC_W-1:0]    intVec,
  output logic [PRIO_W-1:0]   intPrio
);
  logic              busy;
  logic [N_CORE-1:0] remaining;
  logic [IDX_W-1:0]  curIdx;
  logic [VEC_W-1:0]  curVec;
  logic [PRIO_W-1:0] curPrio;
  logic              curDyn;
  logic [ROT_W-1:0]  curCore;

  logic badVec, dropNow, launch, lastAck;

  assign badVec  = selVec < MIN_VEC;
  assign dropNow = !busy && anyElig && badVec;
  assign launch  = !busy && anyElig && !badVec;
  assign lastAck = busy && ((remaining & ~intAck) == '0);

  always_comb begin
    strb.clrPend = lastAck || dropNow;
    strb.setErr  = dropNow;
    strb.rotAdv  = lastAck && curDyn;
    clrIdx       = busy ? curIdx : selIdx;
    rotNew       = (curCore == ROT_W'(N_CORE - 1)) ? '0 : curCore + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
      curIdx    <= '0;
      curVec    <= '0;
      curPrio   <= '0;
      curDyn    <= 1'b0;
      curCore   <= '0;
    end else if (launch) begin
      busy      <= 1'b1;
      remaining <= selDyn ? dynPick : selDest;
      curIdx    <= selIdx;
      curVec    <= selVec;
      curPrio   <= selPrio;
      curDyn    <= selDyn;
      curCore   <= dynIdx;
    end else if (busy) begin
      remaining <= remaining & ~intAck;
      if (lastAck) begin
        busy    <= 1'b0;
        curVec  <= '0;
        curPrio <= '0;
      end
    end
  end

  assign intReq  = remaining;
  assign intVec  = curVec;
  assign intPrio = curPrio;

  // R8: nothing below the external range is ever presented
  a_r8_vec_valid: assert property (@(posedge clk) disable iff (!rstN)
    (intReq != '0) |-> (intVec >= MIN_VEC));

  // R3: a dynamic delivery targets exactly one core
  a_r3_dyn_single: assert property (@(posedge clk) disable iff (!rstN)
    (busy && curDyn) |-> $onehot(intReq));

  // R5: no target is added while a delivery is in progress
  a_r5_no_new_targets: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ((intReq & ~$past(intReq)) == '0));

  // R10: without an acknowledge the presented delivery is frozen
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ((remaining & intAck) == '0)) |=>
      (busy && $stable(intVec) && $stable(intReq) && $stable(intPrio)));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int N_CORE = 4,
  parameter int TPR_W  = 4,
  parameter int PRIO_W = 4,
  localparam int CFG_W  = VEC_W + PRIO_W + N_CORE + 2,
  localparam int ADDR_W = $clog2(N_IRQ + N_CORE + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_IRQ-1:0]   irqIn,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgWdata,
  input  logic [N_CORE-1:0]  intAck,
  output logic [N_CORE-1:0]  intReq,
  output logic [VEC_W-1:0]   intVec,
  output logic [PRIO_W-1:0]  intPrio,
  output logic               errFlag
);
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int ROT_W = (N_CORE > 1) ? $clog2(N_CORE) : 1;

  ctrl_strb_t        strb;
  logic [IDX_W-1:0]  clrIdx, selIdx;
  logic [ROT_W-1:0]  rotNew, dynIdx;
  logic              anyElig, selDyn;
  logic [VEC_W-1:0]  selVec;
  logic [PRIO_W-1:0] selPrio;
  logic [N_CORE-1:0] selDest, dynPick;

  irq_router_dp #(
    .N_IRQ(N_IRQ), .N_CORE(N_CORE), .TPR_W(TPR_W), .PRIO_W(PRIO_W),
    .CFG_W(CFG_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROT_W(ROT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .strb(strb), .clrIdx(clrIdx), .rotNew(rotNew),
    .anyElig(anyElig), .selIdx(selIdx), .selVec(selVec), .selPrio(selPrio),
    .selDest(selDest), .selDyn(selDyn), .dynPick(dynPick), .dynIdx(dynIdx),
    .errFlag(errFlag)
  );

  irq_router_ctrl #(
    .N_CORE(N_CORE), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .ROT_W(ROT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .anyElig(anyElig), .selIdx(selIdx), .selVec(selVec), .selPrio(selPrio),
    .selDest(selDest), .selDyn(selDyn), .dynPick(dynPick), .dynIdx(dynIdx),
    .intAck(intAck), .strb(strb), .clrIdx(clrIdx), .rotNew(rotNew),
    .intReq(intReq), .intVec(intVec), .intPrio(intPrio)
  );
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  irqIn = '0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [17:0] cfgWdata = '0;
  logic [3:0]  intAck = '0;
  logic [3:0]  intReq;
  logic [7:0]  intVec;
  logic [3:0]  intPrio;
  logic        errFlag;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .intAck(intAck), .intReq(intReq), .intVec(intVec),
    .intPrio(intPrio), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [3:0]  irq;
    logic [15:0] tprs;   // core3..core0 nibbles
    logic [7:0]  vec;
    logic [3:0]  prio;
    logic [3:0]  dest;
    logic        dyn;
    logic [3:0]  expReq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{irq:4'd0, tprs:16'h1234, vec:8'h40, prio:4'h1, dest:4'b1111, dyn:1'b1, expReq:4'b1000},
    '{irq:4'd1, tprs:16'h9A2B, vec:8'h41, prio:4'h2, dest:4'b0110, dyn:1'b1, expReq:4'b0010},
    '{irq:4'd2, tprs:16'h0000, vec:8'h20, prio:4'h3, dest:4'b0101, dyn:1'b0, expReq:4'b0101},
    '{irq:4'd3, tprs:16'h0000, vec:8'hFF, prio:4'hF, dest:4'b1111, dyn:1'b0, expReq:4'b1111},
    '{irq:4'd4, tprs:16'h3F00, vec:8'h55, prio:4'h4, dest:4'b1100, dyn:1'b1, expReq:4'b1000},
    '{irq:4'd5, tprs:16'h0000, vec:8'h80, prio:4'h5, dest:4'b0010, dyn:1'b0, expReq:4'b0010},
    '{irq:4'd6, tprs:16'h0F0E, vec:8'h66, prio:4'h6, dest:4'b0101, dyn:1'b1, expReq:4'b0001},
    '{irq:4'd7, tprs:16'h2451, vec:8'h77, prio:4'h7, dest:4'b1010, dyn:1'b1, expReq:4'b1000}
  };

  function automatic logic [17:0] mkEnt(logic [7:0] v, logic [3:0] p, logic [3:0] d,
                                        logic dy, logic m);
    return {m, dy, d, p, v};
  endfunction

  function automatic logic [3:0] rotl(logic [3:0] p);
    return {p[2:0], p[3]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [3:0] a, input logic [17:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    irqIn = m;
    @(negedge clk);
    irqIn = '0;
  endtask

  task automatic waitReq(output logic [3:0] r);
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (intReq != '0) break;
      @(negedge clk);
    end
    r = intReq;
  endtask

  task automatic ack(input logic [3:0] m);
    @(negedge clk);
    intAck = m;
    @(negedge clk);
    intAck = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [3:0] r, p0, p1, p2;
    idle(3);
    // R1: reset state
    chk("R1 req", intReq, 0);
    chk("R1 vec", intVec, 0);
    chk("R1 err", errFlag, 0);
    rstN = 1'b1;
    idle(2);
    // R1: entries start masked, so an edge does nothing
    pulse(8'h01);
    idle(5);
    chk("R1 masked at reset", intReq, 0);

    // table walk: R2 R3 R5
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < 4; c++) wrCfg(4'(8 + c), 18'(VT[v].tprs[c*4 +: 4]));
      wrCfg(VT[v].irq, mkEnt(VT[v].vec, VT[v].prio, VT[v].dest, VT[v].dyn, 1'b0));
      pulse(8'(1) << VT[v].irq);
      waitReq(r);
      chk(VT[v].dyn ? "R3 dyn target" : "R5 static target", r, VT[v].expReq);
      chk("R2 vector", intVec, VT[v].vec);
      chk("R2 priority", intPrio, VT[v].prio);
      ack(VT[v].expReq);
      chk("R5 retired", intReq, 0);
    end
    idle(4);
    chk("R5 no redelivery", intReq, 0);

    // R7: masked line ignores edges, stays silent after unmask
    wrCfg(4'd2, mkEnt(8'h30, 4'h1, 4'b0001, 1'b0, 1'b1));
    pulse(8'h04);
    idle(5);
    chk("R7 masked", intReq, 0);
    wrCfg(4'd2, mkEnt(8'h30, 4'h1, 4'b0001, 1'b0, 1'b0));
    idle(5);
    chk("R7 unmask no replay", intReq, 0);

    // R8: invalid vector dropped, sticky flag, clear
    wrCfg(4'd3, mkEnt(8'h1F, 4'h1, 4'b0001, 1'b0, 1'b0));
    pulse(8'h08);
    idle(5);
    chk("R8 dropped", intReq, 0);
    chk("R8 flag set", errFlag, 1);
    wrCfg(4'd9, 18'h3);
    idle(2);
    chk("R8 flag sticky", errFlag, 1);
    wrCfg(4'd12, 18'h0);
    chk("R8 flag cleared", errFlag, 0);

    // R9: empty destination held, delivered after programming
    wrCfg(4'd4, mkEnt(8'h50, 4'h2, 4'b0000, 1'b1, 1'b0));
    pulse(8'h10);
    idle(5);
    chk("R9 held", intReq, 0);
    wrCfg(4'd4, mkEnt(8'h50, 4'h2, 4'b0010, 1'b1, 1'b0));
    waitReq(r);
    chk("R9 delivered", r, 4'b0010);
    chk("R9 vector", intVec, 8'h50);
    ack(4'b0010);

    // R4: ties rotate, static delivery does not advance
    for (int c = 0; c < 4; c++) wrCfg(4'(8 + c), 18'h5);
    wrCfg(4'd5, mkEnt(8'h90, 4'h3, 4'b1111, 1'b1, 1'b0));
    wrCfg(4'd6, mkEnt(8'h91, 4'h3, 4'b0001, 1'b0, 1'b0));
    pulse(8'h20); waitReq(p0); ack(p0);
    chk("R4 onehot", {31'd0, $onehot(p0)}, 1);
    pulse(8'h20); waitReq(p1); ack(p1);
    chk("R4 rotate 1", p1, rotl(p0));
    pulse(8'h20); waitReq(p2); ack(p2);
    chk("R4 rotate 2", p2, rotl(p1));
    pulse(8'h40); waitReq(r); ack(r);
    chk("R4 static between", r, 4'b0001);
    pulse(8'h20); waitReq(r); ack(r);
    chk("R4 static no advance", r, rotl(p2));

    // R5 R10: partial acknowledges, stray ack
    wrCfg(4'd2, mkEnt(8'hA2, 4'h9, 4'b0111, 1'b0, 1'b0));
    pulse(8'h04); waitReq(r);
    chk("R5 multi", r, 4'b0111);
    ack(4'b0001);
    chk("R5 partial", intReq, 4'b0110);
    chk("R10 vec held", intVec, 8'hA2);
    ack(4'b1010);
    chk("R5 stray ignored", intReq, 4'b0100);
    idle(3);
    chk("R10 still held", intReq, 4'b0100);
    ack(4'b0100);
    chk("R5 done", intReq, 0);

    // R6: simultaneous edges served lowest index first
    wrCfg(4'd1, mkEnt(8'h61, 4'h1, 4'b0001, 1'b0, 1'b0));
    wrCfg(4'd6, mkEnt(8'h66, 4'h1, 4'b0001, 1'b0, 1'b0));
    pulse(8'h42); waitReq(r);
    chk("R6 first", intVec, 8'h61);
    ack(4'b0001); waitReq(r);
    chk("R6 second", intVec, 8'h66);
    ack(4'b0001);
    chk("R6 drained", intReq, 0);

    // R10: target fixed at dispatch
    wrCfg(4'd8, 18'h1);
    wrCfg(4'd9, 18'h8);
    wrCfg(4'd0, mkEnt(8'hC0, 4'h2, 4'b0011, 1'b1, 1'b0));
    pulse(8'h01); waitReq(r);
    chk("R10 pick", r, 4'b0001);
    wrCfg(4'd8, 18'hF);
    chk("R10 target kept", intReq, 4'b0001);
    ack(4'b0001);
    chk("R10 retired", intReq, 0);

    finishRun();
  end
endmodule